// File: doc/BRIEF.md
# Strobed Upper-Address Latch with Chip-Select Decode

This block sits between a processor that time-shares its address pins and a bank of up to four memory devices. It keeps seven high-order address bits steady after the processor's address strobe has gone away. The lower five of those bits leave the block unchanged as upper address lines. The top two are turned into four active-low chip selects, and exactly one of them is low at a time.

The whole block runs on one system clock. The strobe is sampled as an ordinary synchronous level. While the strobe is high, the outputs follow the address inputs combinationally, and a hold register reloads on every clock. Once the strobe is low, the outputs come from the hold register.

A live, active-low chip-enable gates the selects. It acts on the held decode at once, with no new strobe. If the strobe is tied high, the block becomes a plain decoder and buffer for buses that do not multiplex their address.

Top module: `addr_latch_decoder`

## Requirements
- R1: While addrStrobe is high, upperAddr equals addrIn[4:0] in the same cycle, and the decode uses the live addrIn[6:5].
- R2: The hold register loads addrIn on each rising clock edge at which addrStrobe is high. While addrStrobe is low, the outputs show the value captured at the last such edge, whatever addrIn does.
- R3: upperAddr carries bits 4..0 of the effective address with no decoding, bit 0 at position 0.
- R4: With chipEnN low, the effective code c = {bit6, bit5} drives chipSelN[c] low and the other selects high: 00 selects 0, 01 selects 1, 10 selects 2, 11 selects 3.
- R5: With chipEnN high, all four chipSelN bits are high, whatever the strobe and the address are.
- R6: upperAddr does not depend on chipEnN.
- R7: If addrStrobe is held high permanently, every change on addrIn reaches the outputs combinationally, in the same cycle.
- R8: A change of chipEnN while addrStrobe is low changes chipSelN in the same cycle. The held decode is kept, so the same select comes back when chipEnN returns low.
- R9: A synchronous active-high rst clears the hold register to zero, and it takes priority over a load. After reset, with the strobe low, upperAddr is 0 and, with chipEnN low, chipSelN is 4'b1110.
- R10: With chipEnN low, exactly one chipSelN bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the hold register |
| addrStrobe | input | 1 | Address strobe; high = transparent and loading |
| addrIn | input | 7 | High-order address bits from the multiplexed bus |
| chipEnN | input | 1 | Active-low enable for the chip selects |
| upperAddr | output | 5 | Latched upper address lines |
| chipSelN | output | 4 | Active-low one-hot chip selects |

## Verification
The bench walks all four select codes both with the strobe high and with values captured by a falling strobe. This separates a decoder that is wrong in its code order from a latch that is wrong in its capture edge. After each capture, new and unrelated values go onto addrIn while the strobe is low, which exposes any leak from the live inputs into the held outputs. chipEnN is toggled without a strobe to show that the gate is live while the decode stays held, and that upperAddr ignores it. A long run with the strobe held high checks the flow-through behaviour, and a reset with a pending load shows that reset wins.

// File: rtl/lat_dec_pkg.sv
package lat_dec_pkg;
  typedef struct packed {
    logic loadHold;
    logic clearHold;
    logic passLive;
  } latch_ctrl_t;
endpackage

// File: rtl/lat_dec_ctrl.sv
module lat_dec_ctrl
  import lat_dec_pkg::*;
(
  input  logic        rst,
  input  logic        addrStrobe,
  output latch_ctrl_t ctrl
);
  always_comb begin
    ctrl.clearHold = rst;
    ctrl.loadHold  = addrStrobe & ~rst;
    ctrl.passLive  = addrStrobe;
  end
endmodule

// File: rtl/lat_dec_datapath.sv
module lat_dec_datapath
  import lat_dec_pkg::*;
#(
  parameter int UPPER_W = 5,
  parameter int SEL_W   = 2,
  localparam int ADDR_W  = UPPER_W + SEL_W,
  localparam int NUM_SEL = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  latch_ctrl_t        ctrl,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               chipEnN,
  output logic [UPPER_W-1:0] upperAddr,
  output logic [NUM_SEL-1:0] chipSelN
);
  logic [ADDR_W-1:0] holdReg;
  logic [ADDR_W-1:0] effAddr;
  logic [SEL_W-1:0]  selCode;

  always_ff @(posedge clk) begin
    if (ctrl.clearHold)     holdReg <= '0;
    else if (ctrl.loadHold) holdReg <= addrIn;
  end

  assign effAddr   = ctrl.passLive ? addrIn : holdReg;
  assign upperAddr = effAddr[UPPER_W-1:0];
  assign selCode   = effAddr[ADDR_W-1:UPPER_W];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign chipSelN[i] = chipEnN | (selCode != SEL_W'(i));
  end

  a_r5_disable_all_high: assert property (@(posedge clk) disable iff (rst)
    chipEnN |-> (&chipSelN));
  a_r10_exactly_one: assert property (@(posedge clk) disable iff (rst)
    !chipEnN |-> ($countones(chipSelN) == NUM_SEL - 1));
  a_r4_live_decode: assert property (@(posedge clk) disable iff (rst)
    (!chipEnN && ctrl.passLive) |-> (chipSelN[addrIn[ADDR_W-1:UPPER_W]] == 1'b0));
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl.clearHold) && !ctrl.passLive) |-> (upperAddr == '0));
endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder
  import lat_dec_pkg::*;
#(
  parameter int UPPER_W = 5,
  parameter int SEL_W   = 2,
  localparam int ADDR_W  = UPPER_W + SEL_W,
  localparam int NUM_SEL = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               addrStrobe,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               chipEnN,
  output logic [UPPER_W-1:0] upperAddr,
  output logic [NUM_SEL-1:0] chipSelN
);
  latch_ctrl_t ctrl;

  lat_dec_ctrl u_ctrl (
    .rst(rst), .addrStrobe(addrStrobe), .ctrl(ctrl)
  );

  lat_dec_datapath #(.UPPER_W(UPPER_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .addrIn(addrIn),
    .chipEnN(chipEnN), .upperAddr(upperAddr), .chipSelN(chipSelN)
  );

  a_r1_transparent: assert property (@(posedge clk) disable iff (rst)
    addrStrobe |-> (upperAddr == addrIn[UPPER_W-1:0]));
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(!addrStrobe) && $past(!rst) && !addrStrobe) |-> $stable(upperAddr));
endmodule

// File: tb/addr_latch_decoder_bench.sv
module addr_latch_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       addrStrobe = 1'b0;
  logic [6:0] addrIn = '0;
  logic       chipEnN = 1'b1;
  logic [4:0] upperAddr;
  logic [3:0] chipSelN;

  typedef struct {
    logic [4:0] expUpper;
    logic [3:0] expSel;
    string      tag;
  } exp_item_t;

  exp_item_t expQ[$];
  event      sampleEv;
  int        nChecks = 0;
  int        nFails  = 0;
  bit        done    = 1'b0;

  logic [6:0] modelHeld = '0;
  logic       prevStrobe = 1'b0;
  logic       prevRst    = 1'b1;
  logic [6:0] prevAddr   = '0;

  always #10 clk = ~clk;

  addr_latch_decoder u_addr_latch_decoder (
    .clk(clk), .rst(rst), .addrStrobe(addrStrobe), .addrIn(addrIn),
    .chipEnN(chipEnN), .upperAddr(upperAddr), .chipSelN(chipSelN)
  );

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        exp_item_t it;
        it = expQ.pop_front();
        nChecks++;
        if (upperAddr !== it.expUpper || chipSelN !== it.expSel) begin
          nFails++;
          $display("FAIL %s: upper=%h sel=%b expected upper=%h sel=%b",
                   it.tag, upperAddr, chipSelN, it.expUpper, it.expSel);
        end
      end
    end
  end

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic stb, input logic [6:0] a, input logic ce,
                      input logic r, input string tag);
    logic [6:0] eff;
    @(negedge clk);
    if (prevRst) modelHeld = '0;
    else if (prevStrobe) modelHeld = prevAddr;
    addrStrobe = stb; addrIn = a; chipEnN = ce; rst = r;
    prevStrobe = stb; prevAddr = a; prevRst = r;
    #2;
    eff = stb ? a : modelHeld;
    expQ.push_back('{eff[4:0], ce ? 4'b1111 : ~(4'b0001 << eff[6:5]), tag});
    ->sampleEv;
    #1;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    step(1'b0, 7'h00, 1'b1, 1'b1, "R9 reset ce high");
    step(1'b1, 7'h7F, 1'b0, 1'b1, "R9 reset beats load");
    step(1'b0, 7'h55, 1'b0, 1'b0, "R9 cleared held decode");
    // R1 R4 R10 live decode of each code
    for (int c = 0; c < 4; c++) begin
      step(1'b1, {c[1:0], 5'h0A + 5'(c)}, 1'b0, 1'b0, "R1 R4 R10 live code");
    end
    // R2 R3 capture each code then disturb inputs with strobe low
    for (int c = 0; c < 4; c++) begin
      step(1'b1, {c[1:0], 5'h11 ^ 5'(c)}, 1'b0, 1'b0, "R3 load");
      step(1'b0, {c[1:0], 5'h11 ^ 5'(c)}, 1'b0, 1'b0, "R2 fall");
      step(1'b0, {~c[1:0], 5'h0E}, 1'b0, 1'b0, "R2 hold vs new input");
      step(1'b0, 7'h7F ^ 7'(c), 1'b0, 1'b0, "R2 R10 hold again");
    end
    // R5 R6 R8 toggle enable with strobe low
    step(1'b1, 7'b10_10110, 1'b0, 1'b0, "R8 load code2");
    step(1'b0, 7'h01, 1'b1, 1'b0, "R5 R6 disabled held");
    step(1'b0, 7'h3C, 1'b0, 1'b0, "R8 reenabled same select");
    step(1'b0, 7'h3C, 1'b1, 1'b0, "R5 R6 disabled again");
    step(1'b1, 7'h63, 1'b1, 1'b0, "R5 disabled while strobe high");
    step(1'b0, 7'h00, 1'b0, 1'b0, "R8 held after disabled load");
    // R7 flow-through with strobe held high
    for (int k = 0; k < 24; k++) begin
      step(1'b1, 7'((k * 37) ^ 7'h2A), k[0], 1'b0, "R7 flow-through");
    end
    step(1'b0, 7'h15, 1'b0, 1'b0, "R7 R2 last flow value held");
    step(1'b0, 7'h00, 1'b1, 1'b1, "R9 second reset");
    step(1'b0, 7'h6B, 1'b0, 1'b0, "R9 post reset zero");
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule